// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked system and an asynchronous static RAM with a 20-bit address, a 1-bit data input pin, a 1-bit data output pin and active-low chip-select and write-strobe controls. A client presents one request at a time on a valid/ready handshake. A request carries an address, a write flag and a write bit. The sequencer then produces the RAM control waveforms from registered outputs. On a read it samples the RAM output and returns the bit with a one-cycle completion pulse. On a write it issues the same completion pulse once the cycle has closed.

Each timing interval of the RAM is a parameter counted in whole clock cycles, rounded up: address-to-data time, read cycle time, write-strobe width, data setup before write end, and write cycle time. A single shared down-counter times each phase of a small state machine. Between accesses the chip is always deselected, so the RAM falls back into its automatic low-power standby. Every write is closed by raising the write strobe while the chip stays selected for the recovery phase, with address and data held unchanged.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, `ram_ce_n` and `ram_we_n` are 1, `req_ready` is 1 and `done` is 0.
- R2: When no access is in progress, `ram_ce_n` and `ram_we_n` are both 1. `req_ready` is 1 only in that idle state and drops in the cycle after a request is accepted.
- R3: A read accepted at clock edge k drives `ram_ce_n` low and the request address onto `ram_addr` from edge k, with `ram_we_n` held high. The chip stays selected for exactly RD_LEN cycles, where RD_LEN = max(CYC_AA, CYC_RC, 2), and `ram_ce_n` returns high at edge k+RD_LEN.
- R4: A read samples `ram_dout` at edge k+RD_LEN and presents it on `rdata` in the cycle in which `done` is 1. `rdata` changes at no other time; writes leave it unchanged.
- R5: A write accepted at edge k selects the chip for one cycle with `ram_we_n` high. It then holds `ram_we_n` low for PW_LEN = max(CYC_PWE, CYC_SD, 1) cycles, then keeps `ram_we_n` high with the chip still selected for REC_LEN = max(1, CYC_WC-PW_LEN-1) cycles. `ram_ce_n` returns high at edge k+1+PW_LEN+REC_LEN.
- R6: For the whole time `ram_ce_n` is low, `ram_addr` and `ram_din` stay constant and equal to the accepted request address and write bit.
- R7: `ram_we_n` is never low while `ram_ce_n` is high, and a write is always ended by `ram_we_n` rising while `ram_ce_n` is still low.
- R8: `done` is 1 for exactly one cycle per accepted request, in the cycle in which `ram_ce_n` has just returned high.
- R9: `req_valid` asserted while `req_ready` is 0 is ignored: the access in progress keeps its waveform, address and data, and no extra access follows.
- R10: A read returns the bit most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 1 | Bit to write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 1 | Bit returned by the last read |
| ram_addr | output | ADDR_W | RAM address lines |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_din | output | 1 | RAM data input pin |
| ram_dout | input | 1 | RAM data output pin |

## Verification
All pins are registered, so the RAM controls for a request accepted at edge k change at edge k. The bench samples them at the falling edge after each of edges k through k+RD_LEN (read) or k+1+PW_LEN+REC_LEN (write), and compares each sample with the phase the requirements give for that cycle offset. `done`, `ready` and `rdata` are due at the final edge of the window and are checked at the falling edge that follows it. The RAM model only returns the stored bit once 12 ns have passed since the address and select settled, and returns its inverse before that, so a sample taken too early shows up as a data miscompare. The model also counts short write strobes, late data and address movement during a write.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_WAIT    = 3'd1,
    ST_RD_CAPTURE = 3'd2,
    ST_WR_SETUP   = 3'd3,
    ST_WR_PULSE   = 3'd4,
    ST_WR_RECOVER = 3'd5
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int RD_LD  = 1,
  parameter int PW_LD  = 1,
  parameter int REC_LD = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  output seq_state_e       state,
  output seq_state_e       nxt,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] RD_LD_V  = CNT_W'(RD_LD);
  localparam logic [CNT_W-1:0] PW_LD_V  = CNT_W'(PW_LD);
  localparam logic [CNT_W-1:0] REC_LD_V = CNT_W'(REC_LD);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt      = state;
    accept   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            nxt = ST_WR_SETUP;
          end else begin
            nxt      = ST_RD_WAIT;
            tmr_load = 1'b1;
            tmr_val  = RD_LD_V;
          end
        end
      end
      ST_RD_WAIT: begin
        if (tmr_zero) nxt = ST_RD_CAPTURE;
      end
      ST_RD_CAPTURE: begin
        nxt = ST_IDLE;
      end
      ST_WR_SETUP: begin
        nxt      = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = PW_LD_V;
      end
      ST_WR_PULSE: begin
        if (tmr_zero) begin
          nxt      = ST_WR_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = REC_LD_V;
        end
      end
      ST_WR_RECOVER: begin
        if (tmr_zero) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state,
  input  seq_state_e        nxt,
  input  logic              accept,
  input  logic              tmr_zero,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  input  logic              ram_dout,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_din,
  output logic              req_ready,
  output logic              done,
  output logic              rdata
);

  logic capture;
  logic wr_close;

  assign capture  = (state == ST_RD_CAPTURE);
  assign wr_close = (state == ST_WR_RECOVER) && tmr_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_ce_n  <= 1'b1;
      ram_we_n  <= 1'b1;
      req_ready <= 1'b1;
      done      <= 1'b0;
      rdata     <= 1'b0;
      ram_addr  <= '0;
      ram_din   <= 1'b0;
    end else begin
      ram_ce_n  <= (nxt == ST_IDLE);
      ram_we_n  <= (nxt != ST_WR_PULSE);
      req_ready <= (nxt == ST_IDLE);
      done      <= capture || wr_close;
      if (capture) rdata <= ram_dout;
      if (accept) begin
        ram_addr <= req_addr;
        ram_din  <= req_wdata;
      end
    end
  end

  AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> !ram_ce_n);  // R7

  AST_STROBE_ENDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_ce_n) |-> $past(ram_we_n));  // R7

  AST_PINS_HELD: assert property (@(posedge clk) disable iff (rst)
    !ram_ce_n |=> (ram_ce_n || ($stable(ram_addr) && $stable(ram_din))));  // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R8

  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ram_ce_n && ram_we_n));  // R2

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rdata));  // R4

  AST_DONE_AT_DESELECT: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(ram_ce_n));  // R8

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int CYC_AA  = 3,
  parameter int CYC_RC  = 3,
  parameter int CYC_PWE = 2,
  parameter int CYC_SD  = 2,
  parameter int CYC_WC  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              done,
  output logic              rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_din,
  input  logic              ram_dout
);

  localparam int unsigned RD_LEN  = max2(max2(CYC_AA, CYC_RC), 2);
  localparam int unsigned PW_LEN  = max2(max2(CYC_PWE, CYC_SD), 1);
  localparam int unsigned REC_LEN = (CYC_WC > PW_LEN + 1) ? (CYC_WC - PW_LEN - 1) : 1;
  localparam int unsigned CNT_MAX = max2(max2(RD_LEN, PW_LEN), REC_LEN);
  localparam int          CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e       state;
  seq_state_e       nxt;
  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  sram_phase_timer #(
    .CNT_W(CNT_W)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  sram_seq_fsm #(
    .CNT_W (CNT_W),
    .RD_LD (int'(RD_LEN) - 2),
    .PW_LD (int'(PW_LEN) - 1),
    .REC_LD(int'(REC_LEN) - 1)
  ) fsm_i (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .tmr_zero (tmr_zero),
    .state    (state),
    .nxt      (nxt),
    .accept   (accept),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  sram_pin_drive #(
    .ADDR_W(ADDR_W)
  ) pins_i (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .nxt      (nxt),
    .accept   (accept),
    .tmr_zero (tmr_zero),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .ram_dout (ram_dout),
    .ram_addr (ram_addr),
    .ram_ce_n (ram_ce_n),
    .ram_we_n (ram_we_n),
    .ram_din  (ram_din),
    .req_ready(req_ready),
    .done     (done),
    .rdata    (rdata)
  );

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);  // R2

endmodule

// File: tb/sram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb_top;

  localparam int AW      = 20;
  localparam int CYC_AA  = 3;
  localparam int CYC_RC  = 3;
  localparam int CYC_PWE = 2;
  localparam int CYC_SD  = 2;
  localparam int CYC_WC  = 5;
  localparam int MAW     = 10;
  localparam int DEPTH   = 1 << MAW;
  localparam real TAA_NS  = 12.0;
  localparam real TPWE_NS = 10.0;
  localparam real TSD_NS  = 7.0;

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int rd_len();
    return mx(mx(CYC_AA, CYC_RC), 2);
  endfunction
  function automatic int pw_len();
    return mx(mx(CYC_PWE, CYC_SD), 1);
  endfunction
  function automatic int rec_len();
    return (CYC_WC > pw_len() + 1) ? CYC_WC - pw_len() - 1 : 1;
  endfunction

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic          req_valid, req_ready, req_write, req_wdata;
  logic [AW-1:0] req_addr;
  logic          done, rdata;
  logic [AW-1:0] ram_addr;
  logic          ram_ce_n, ram_we_n, ram_din, ram_dout;

  sram_seq_ctrl #(
    .ADDR_W(AW), .CYC_AA(CYC_AA), .CYC_RC(CYC_RC),
    .CYC_PWE(CYC_PWE), .CYC_SD(CYC_SD), .CYC_WC(CYC_WC)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
    .ram_we_n(ram_we_n), .ram_din(ram_din), .ram_dout(ram_dout)
  );

  // Behavioural RAM of reduced depth with a timing checker
  logic model_mem [DEPTH];
  logic model_ok;
  real  chg_t = 0.0;
  real  we_fall_t = 0.0;
  real  din_t = 0.0;
  int   tv_write = 0;
  int   tv_addr = 0;
  int   ce_end = 0;

  always @(ram_addr or ram_ce_n or ram_we_n) chg_t = $realtime;
  always @(ram_din) din_t = $realtime;
  always @(negedge ram_we_n) we_fall_t = $realtime;
  always #0.5 model_ok = !ram_ce_n && ram_we_n && (($realtime - chg_t) >= TAA_NS);

  assign ram_dout = model_ok ? model_mem[ram_addr[MAW-1:0]] : ~model_mem[ram_addr[MAW-1:0]];

  always @(posedge ram_we_n or posedge ram_ce_n) begin
    if (!rst) begin
      if (!ram_ce_n) begin
        if (($realtime - we_fall_t) < TPWE_NS) tv_write++;
        if (($realtime - din_t) < TSD_NS) tv_write++;
        model_mem[ram_addr[MAW-1:0]] = ram_din;
      end else if (!ram_we_n) begin
        ce_end++;
        model_mem[ram_addr[MAW-1:0]] = ram_din;
      end
    end
  end

  always @(ram_addr) if (!rst && !ram_ce_n && !ram_we_n) tv_addr++;

  // Bench bookkeeping
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;
  logic sh_val [DEPTH];
  bit   sh_known [DEPTH];
  logic last_rd;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      // R2 / R9: deselected, ready, no spurious completion
      chk(ram_ce_n && ram_we_n && req_ready && !done, "R2", "idle pins {ce,we,rdy,done}",
          {ram_ce_n, ram_we_n, req_ready, done}, 4'b1110);
    end
  endtask

  task automatic run_access(input bit wr, input logic [AW-1:0] a, input logic d);
    int   len;
    int   bad_shape, bad_hold, bad_flow;
    int   act_shape, exp_shape;
    int   tw0, ta0, ce0;
    bit   exp_we;
    logic rd_before;
    len       = wr ? (1 + pw_len() + rec_len()) : rd_len();
    bad_shape = 0; bad_hold = 0; bad_flow = 0;
    act_shape = 0; exp_shape = 0;
    tw0 = tv_write; ta0 = tv_addr; ce0 = ce_end;
    rd_before = rdata;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    for (int j = 0; j <= len; j++) begin
      @(negedge clk);
      if (j < len) begin
        exp_we = wr ? !(j >= 1 && j <= pw_len()) : 1'b1;
        if (ram_ce_n !== 1'b0 || ram_we_n !== exp_we) begin
          if (bad_shape == 0) begin
            act_shape = {ram_ce_n, ram_we_n}; exp_shape = {1'b0, exp_we};
          end
          bad_shape++;
        end
        if (ram_addr !== a || ram_din !== d) bad_hold++;
        if (req_ready !== 1'b0 || done !== 1'b0) bad_flow++;
        if (!wr && rdata !== rd_before) bad_flow++;
        // R9: noise on the request side while busy
        req_valid = 1'b1; req_write = 1'($urandom);
        req_addr = AW'($urandom); req_wdata = 1'($urandom);
      end else begin
        req_valid = 1'b0;
        if (ram_ce_n !== 1'b1 || ram_we_n !== 1'b1) begin
          if (bad_shape == 0) begin
            act_shape = {ram_ce_n, ram_we_n}; exp_shape = 3;
          end
          bad_shape++;
        end
        if (req_ready !== 1'b1 || done !== 1'b1) bad_flow++;
      end
    end
    if (wr) chk(bad_shape == 0, "R5", "write phase pins {ce,we}", act_shape, exp_shape);
    else    chk(bad_shape == 0, "R3", "read phase pins {ce,we}", act_shape, exp_shape);
    chk(bad_hold == 0, "R6", "addr/din changed during select or R9 noise leaked", bad_hold, 0);
    chk(bad_flow == 0, "R8", "ready/done sequence errors", bad_flow, 0);
    chk(ce_end == ce0 && tv_write == tw0, "R7", "write timing/termination faults",
        (ce_end - ce0) + (tv_write - tw0), 0);
    chk(tv_addr == ta0, "R6", "address moved during write", tv_addr - ta0, 0);
    if (wr) begin
      sh_val[a[MAW-1:0]] = d;
      sh_known[a[MAW-1:0]] = 1'b1;
      chk(rdata === last_rd, "R4", "rdata disturbed by write", int'(rdata), int'(last_rd));
    end else begin
      if (sh_known[a[MAW-1:0]]) begin
        chk(rdata === sh_val[a[MAW-1:0]], "R10", "read data", int'(rdata),
            int'(sh_val[a[MAW-1:0]]));
        last_rd = sh_val[a[MAW-1:0]];
      end else begin
        last_rd = rdata;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0107));
    for (int i = 0; i < DEPTH; i++) sh_known[i] = 1'b0;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = 1'b0;
    last_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk(ram_ce_n && ram_we_n && req_ready && !done, "R1", "reset pins {ce,we,rdy,done}",
        {ram_ce_n, ram_we_n, req_ready, done}, 4'b1110);
    rst = 1'b0;
    @(negedge clk);
    chk(ram_ce_n && ram_we_n && req_ready && !done, "R1", "post-reset pins {ce,we,rdy,done}",
        {ram_ce_n, ram_we_n, req_ready, done}, 4'b1110);
    chk(rdata === 1'b0, "R4", "rdata after reset", int'(rdata), 0);

    // Directed corners
    run_access(1'b1, 20'h00000, 1'b1);
    idle_gap(1);
    run_access(1'b0, 20'h00000, 1'b0);
    run_access(1'b1, 20'hFFFFF, 1'b0);     // back to back, top address
    run_access(1'b0, 20'hFFFFF, 1'b0);
    run_access(1'b1, 20'h00000, 1'b0);     // overwrite then read
    run_access(1'b0, 20'h00000, 1'b0);
    run_access(1'b0, 20'hFFFFF, 1'b0);     // read after read
    idle_gap(2);

    // Constrained random traffic over a small address pool
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = {AW'($urandom) & ~AW'(DEPTH - 1)} | AW'($urandom_range(0, 31));
      run_access(($urandom_range(0, 99) < 45), a, 1'($urandom));
      idle_gap($urandom_range(0, 2));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule